// File: doc/BRIEF.md
# Device Interrupt Mask Router

This block steers a set of device interrupt request lines (64 by default) to a small group of processors (four by default). Devices raise and drop their requests through per-line post and clear strobes. Those strobes set and clear bits in one shared pending-request register. Each processor owns a mask register that selects which lines may interrupt it. A per-processor routed register always holds that processor's mask ANDed with the pending requests. Each processor gets one level-sensitive interrupt output, which is high while its routed register has any bit set.

Software reaches the registers through a plain register port: a register index, a write enable, write data, and combinational read data. The index is the byte offset of the register shifted right by six. Mask registers can be read and written. Routed registers and the pending register can only be read. A write to one of them changes nothing and raises a one-cycle error pulse.

All ports are plain control and data pins. There is no streaming data path and no valid/ready handshake. Strobes and writes are sampled on every rising clock edge and cannot be stalled.

Top module: `irq_mask_router`

## Requirements
- R1: After reset, every mask, routed and pending register reads 0, every interrupt output is low and the error output is low.
- R2: A write with the index set to 0..NUM_CPU-1 replaces that processor's mask register with the write data. The new value reads back at the same index from the following cycle on, and the other masks are unchanged.
- R3: At every cycle, the register at index NUM_CPU+c reads the mask of processor c ANDed with the pending register.
- R4: A post strobe on line n sets bit n of the pending register, which is at index 2*NUM_CPU. After that edge, every processor whose mask has bit n set has its interrupt output high.
- R5: A clear strobe on a line that is not pending changes no register and no output. A clear strobe on a pending line drops its pending bit. A processor's interrupt goes low once no routed bit remains for it.
- R6: A mask write that sets a bit whose line is pending raises that processor's interrupt at that edge. A mask write that removes the last routed bit drops the interrupt at that edge.
- R7: A write to any index from NUM_CPU to 2*NUM_CPU leaves every register unchanged. The error output is high for exactly the one cycle after that write's edge.
- R8: When a mask write and a post strobe arrive in the same cycle, the routed register and the interrupt output reflect both the new mask and the new pending bits after that edge.
- R9: When a post and a clear strobe for the same line arrive in the same cycle, the clear wins and the pending bit ends at 0.
- R10: Indices above 2*NUM_CPU read as 0. Writes to them change no register and raise no error.
- R11: Interrupt output c is high exactly when routed register c is nonzero. Both update on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | IDX_W | Register index (byte offset >> 6) for read and write |
| reg_wr_en | input | 1 | Write strobe for the indexed register |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Combinational read data of the indexed register |
| line_post | input | NUM_LINES | Per-line post strobes, one bit per device line |
| line_clear | input | NUM_LINES | Per-line clear strobes, one bit per device line |
| cpu_irq | output | NUM_CPU | Level interrupt per processor |
| wr_err | output | 1 | One-cycle pulse after a write to a read-only index |

## Verification
A wrong pending or mask bit shows up in two places. The read port shows it on the very next cycle, because the routed readback no longer matches the mask ANDed with the pending register. The interrupt outputs show it from the same edge, rising where no enabled line is pending or staying low where one is. An ordering fault in simultaneous strobes or writes stands out right after the edge in which they coincide: for example, a stale mask used for routing, or a post that beats a clear on the same line. A read-only write that leaks into state changes a readback value at once, and the missing or stretched error pulse is visible in the cycle after the write.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  typedef enum logic [1:0] {RK_MASK, RK_ROUTED, RK_RAW, RK_NONE} reg_kind_e;

  // Register regions: masks, then routed copies, then the pending word.
  function automatic reg_kind_e kind_of(input logic [31:0] idx, input int unsigned ncpu);
    if (idx < ncpu) return RK_MASK;
    if (idx < 2 * ncpu) return RK_ROUTED;
    if (idx == 2 * ncpu) return RK_RAW;
    return RK_NONE;
  endfunction
endpackage

// File: rtl/irqr_pending.sv
module irqr_pending #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] post_i,
  input  logic [NUM_LINES-1:0] clear_i,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] pend_d
);
  // Clear takes precedence over post on the same line.
  always_comb pend_d = (pend_q | post_i) & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R4: a post without a matching clear leaves its bit set
  p_post_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i & ~clear_i) != '0 |=> (pend_q & $past(post_i & ~clear_i)) == $past(post_i & ~clear_i));
  // R5: without post or clear strobes the pending word holds
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i == '0 && clear_i == '0) |=> $stable(pend_q));
  // R9: a cleared line is never pending after the edge
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i != '0 |=> (pend_q & $past(clear_i)) == '0);
endmodule

// File: rtl/irqr_cpu_slice.sv
module irqr_cpu_slice #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pend_q_i,
  input  logic [DATA_W-1:0] pend_d_i,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] routed_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] mask_d, routed_d;

  // Route from the next mask and next pending value together.
  always_comb begin
    mask_d   = mask_we_i ? wr_data_i : mask_q;
    routed_d = mask_d & pend_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      routed_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      routed_q <= routed_d;
      irq_q    <= |routed_d;
    end
  end

  // R3: routed copy tracks mask and pending registers
  p_routed_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    routed_q == (mask_q & pend_q_i));
  // R11: interrupt level agrees with the routed register
  p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (routed_q != '0));
  // R2: mask changes only on its own write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irqr_regdec.sv
module irqr_regdec
  import irqr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0] masks_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0] routed_i,
  input  logic [DATA_W-1:0]              pend_i,
  output logic [NUM_CPU-1:0]             mask_we_o,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           wr_err_o
);
  logic [31:0] idx_u;
  reg_kind_e   kind;
  logic        ro_hit;

  always_comb begin
    idx_u     = 32'(idx_i);
    kind      = kind_of(idx_u, NUM_CPU);
    mask_we_o = '0;
    rd_data_o = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (kind == RK_MASK && idx_u == 32'(c)) begin
        mask_we_o[c] = wr_en_i;
        rd_data_o    = masks_i[c];
      end
      if (kind == RK_ROUTED && idx_u == 32'(c + NUM_CPU)) rd_data_o = routed_i[c];
    end
    if (kind == RK_RAW) rd_data_o = pend_i;
    ro_hit = wr_en_i && (kind == RK_ROUTED || kind == RK_RAW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err_o <= 1'b0;
    else        wr_err_o <= ro_hit;
  end

  // R7: no error pulse without a write in the cycle before
  p_err_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !wr_err_o);
  // R2: at most one mask enabled per write
  p_one_mask_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we_o));
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router #(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic                 reg_wr_en,
  input  logic [NUM_LINES-1:0] reg_wr_data,
  output logic [NUM_LINES-1:0] reg_rd_data,
  input  logic [NUM_LINES-1:0] line_post,
  input  logic [NUM_LINES-1:0] line_clear,
  output logic [NUM_CPU-1:0]   cpu_irq,
  output logic                 wr_err
);
  localparam int DATA_W = NUM_LINES;

  logic [DATA_W-1:0]              pend_q, pend_d;
  logic [NUM_CPU-1:0][DATA_W-1:0] masks, routed;
  logic [NUM_CPU-1:0]             mask_we;

  irqr_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .post_i(line_post), .clear_i(line_clear),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irqr_cpu_slice #(.DATA_W(DATA_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .mask_we_i(mask_we[c]), .wr_data_i(reg_wr_data),
      .pend_q_i(pend_q), .pend_d_i(pend_d),
      .mask_q(masks[c]), .routed_q(routed[c]), .irq_q(cpu_irq[c])
    );
  end

  irqr_regdec #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .idx_i(reg_idx),
    .masks_i(masks), .routed_i(routed), .pend_i(pend_q),
    .mask_we_o(mask_we), .rd_data_o(reg_rd_data), .wr_err_o(wr_err)
  );

  // R7: a read-only write with no strobes leaves the pending word intact
  p_ro_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && 32'(reg_idx) >= 32'(NUM_CPU) && line_post == '0 && line_clear == '0)
    |=> $stable(pend_q) && $stable(masks));
endmodule

// File: tb/irq_mask_router_tb.sv
module irq_mask_router_tb;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam int IW = 4;

  logic          clk = 0, rst_n = 0;
  logic [IW-1:0] reg_idx = '0;
  logic          reg_wr_en = 0;
  logic [NL-1:0] reg_wr_data = '0, reg_rd_data, line_post = '0, line_clear = '0;
  logic [NC-1:0] cpu_irq;
  logic          wr_err;

  int n_chk = 0, n_fail = 0;
  logic [NL-1:0] m_mask [NC];
  logic [NL-1:0] m_pend;

  always #10 clk = ~clk;

  irq_mask_router #(.NUM_CPU(NC), .NUM_LINES(NL), .IDX_W(IW)) u_dut (.*);

  task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = |(m_mask[c] & m_pend);
    return r;
  endfunction

  task automatic rd(input int idx, output logic [NL-1:0] v);
    reg_idx = IW'(idx);
    #1 v = reg_rd_data;
  endtask

  // Full state comparison at the ports (called at negedge).
  task automatic check_state(input string req);
    logic [NL-1:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(c, v);      chk({req, " mask"}, v, m_mask[c]);
      rd(c + NC, v); chk({req, " routed (R3)"}, v, m_mask[c] & m_pend);
    end
    rd(2 * NC, v); chk({req, " pending"}, v, m_pend);
    chk({req, " irq (R11)"}, NL'(cpu_irq), NL'(exp_irq()));
  endtask

  // One cycle of stimulus; returns sampled error flag after the edge.
  task automatic cycle(input logic we, input int idx, input logic [NL-1:0] wd,
                       input logic [NL-1:0] p, input logic [NL-1:0] cl, output logic err);
    @(negedge clk);
    reg_wr_en = we; reg_idx = IW'(idx); reg_wr_data = wd; line_post = p; line_clear = cl;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 0; line_post = '0; line_clear = '0;
    err = wr_err;
    if (we && idx < NC) m_mask[idx] = wd;
    m_pend = (m_pend | p) & ~cl;
  endtask

  task automatic t_reset;
    logic [NL-1:0] v;
    @(negedge clk);
    check_state("R1");
    chk("R1 err", NL'(wr_err), '0);
    rd(15, v); chk("R10 unmapped read", v, '0);
  endtask

  task automatic t_mask_rw;
    logic e;
    cycle(1, 2, 64'hF0F0_0000_1234_5678, '0, '0, e);
    check_state("R2");
    cycle(1, 2, 64'h0000_0000_0000_0011, '0, '0, e);
    check_state("R2 replace");
    chk("R2 no err", NL'(e), '0);
  endtask

  task automatic t_post;
    logic e;
    cycle(1, 0, 64'h1, '0, '0, e);
    cycle(1, 1, 64'h8000_0000_0000_0000, '0, '0, e);
    cycle(0, 0, '0, 64'h8000_0000_0000_0010, '0, e);
    check_state("R4 post");
    chk("R4 cpu1 irq", NL'(cpu_irq[1]), 1);
    chk("R4 cpu0 irq", NL'(cpu_irq[0]), 0);
  endtask

  task automatic t_clear;
    logic e;
    cycle(0, 0, '0, '0, 64'h0000_0000_0000_0100, e);
    check_state("R5 clear idle");
    chk("R5 cpu1 still", NL'(cpu_irq[1]), 1);
    cycle(0, 0, '0, '0, 64'h8000_0000_0000_0000, e);
    check_state("R5 clear pending");
    chk("R5 cpu1 dropped", NL'(cpu_irq[1]), 0);
  endtask

  task automatic t_mask_edges;
    logic e;
    cycle(1, 3, 64'h10, '0, '0, e);
    chk("R6 raise", NL'(cpu_irq[3]), 1);
    cycle(1, 3, 64'h20, '0, '0, e);
    chk("R6 drop", NL'(cpu_irq[3]), 0);
    check_state("R6");
  endtask

  task automatic t_readonly;
    logic e;
    for (int i = NC; i <= 2 * NC; i++) begin
      cycle(1, i, '1, '0, '0, e);
      chk("R7 err pulse", NL'(e), 1);
      check_state("R7 unchanged");
    end
    @(negedge clk);
    chk("R7 err one cycle", NL'(wr_err), 0);
    cycle(1, 12, '1, '0, '0, e);
    chk("R10 no err", NL'(e), 0);
    check_state("R10 unchanged");
  endtask

  task automatic t_simul;
    logic e;
    cycle(1, 0, 64'h0400, 64'h0400, '0, e);
    chk("R8 irq", NL'(cpu_irq[0]), 1);
    check_state("R8");
    cycle(0, 0, '0, 64'h0800, 64'h0800, e);
    check_state("R9 clear wins");
    cycle(1, 2, 64'h0800, 64'h0800, 64'h0400, e);
    check_state("R9 mixed");
    chk("R9 cpu0 low", NL'(cpu_irq[0]), 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    m_pend = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    t_reset;
    t_mask_rw;
    t_post;
    t_clear;
    t_mask_edges;
    t_readonly;
    t_simul;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule